// File: doc/BRIEF.md
# Network Interface Register Access Decoder

This block sits between a simple processor request port and the control registers of a network interface. The register window is 0x68 bytes long. Each 4-byte slot in it has its own access width, which is either one word or a double word. Each slot also has its own read and write rights, and some slots are unused holes. For every request, the block checks the address, the requested width and the direction against the descriptor of the addressed slot. It then returns a registered response: valid, error and read data.

Accepted accesses have side effects:
- Writes update the configuration register, the interrupt mask, the interrupt status and the two DMA descriptor registers.
- Reading the interrupt status hands back its value and clears it.
- Writing a one to bit 0 of the write-only command register clears the device state and raises a one-cycle device reset pulse.

Interrupt sources can set status bits at any time, and no such event is ever dropped.

Top module: `nic_reg_decoder`

## Requirements
- R1: Synchronous reset clears the following to zero: rsp_valid, rsp_err, rsp_rdata, cfg_o, imr_o, rx_desc_o, tx_desc_o, dev_reset_o and the interrupt status.
- R2: A request seen at a rising edge with req_valid high produces rsp_valid high for exactly the following cycle. Without a request, rsp_valid, rsp_err and rsp_rdata are all zero.
- R3: The slots and their widths are as follows. Byte offsets 0x00, 0x04, 0x08 and 0x0C are word slots: configuration, command, interrupt status and interrupt mask. The word slots 0x10, 0x14, 0x18, 0x20, 0x24, 0x28 and 0x2C hold limits. Offsets 0x30, 0x38, 0x40, 0x48, 0x50, 0x58 and 0x60 are double-word slots: receive descriptor, receive done, receive wait, transmit descriptor, transmit done, transmit wait and hardware address. An access is in error in any of these cases: it is at or beyond 0x68; its address bits [1:0] are not zero; it targets 0x1C; or it targets the upper half (+4) of a double-word slot.
- R4: req_size 0 requests a word and 1 requests a double word. A request whose width differs from the slot width is in error. It returns zero data and changes no state.
- R5: Configuration, interrupt status, interrupt mask and both descriptor slots may be read and written. The command slot may only be written, and all other slots may only be read. An access that breaks these rights is in error, returns zero data and changes no state.
- R6: An accepted read returns the addressed value, zero-extended to 64 bits: the limit parameters, the done/wait inputs or the hardware-address parameter. Writes return zero data.
- R7: A configuration write stores wdata[8:0] into cfg_o. The fields are receive enable 0, transmit enable 1, interrupt enable 2, poll 3, descriptors 4, virtual addressing 5, VLAN 6, filter 7 and dedicated thread 8. A mask write stores wdata[7:0] into imr_o. Higher bits are dropped.
- R8: An accepted read of the interrupt status returns the value held before the edge and then clears it. Any irq_set bits present in that same cycle remain set afterwards.
- R9: A bit of irq_set that is high at an edge sets the matching status bit. An accepted status write loads wdata[7:0], and irq_set bits from the same cycle are ORed in.
- R10: An accepted command write with wdata[0]=1 clears cfg_o, imr_o, both descriptors and the status at that edge, and only that cycle's irq_set bits survive. dev_reset_o is high in the following cycle. With wdata[0]=0 the write has no effect.
- R11: Accepted descriptor writes store all 64 bits into rx_desc_o (offset 0x30) or tx_desc_o (offset 0x48).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 1 | 0 = word, 1 = double word |
| req_wdata | input | 64 | Write data |
| irq_set | input | IRQ_W | Interrupt event pulses |
| rx_done_i | input | 64 | Receive done value |
| rx_wait_i | input | 64 | Receive wait value |
| tx_done_i | input | 64 | Transmit done value |
| tx_wait_i | input | 64 | Transmit wait value |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 64 | Read data |
| cfg_o | output | CFG_W | Configuration register |
| imr_o | output | IRQ_W | Interrupt mask register |
| rx_desc_o | output | 64 | Receive descriptor |
| tx_desc_o | output | 64 | Transmit descriptor |
| dev_reset_o | output | 1 | One-cycle device reset pulse |

## Verification
The response flops capture a request at the rising edge on which it is presented. The register outputs and the status update at that same edge, and so does the device reset pulse, so every result becomes visible one edge after the stimulus. The bench drives each request on a falling edge and waits for the next rising edge. It then compares everything on the falling edge that follows, against a model that is advanced once per request. Since the status cannot be seen directly, it is observed through status reads. Those reads include reads issued in the same cycle as a new event.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

  typedef struct packed {
    logic used;
    logic wide;
    logic rd;
    logic wr;
  } slot_t;

  localparam int SLOT_CFG       = 0;
  localparam int SLOT_CMD       = 1;
  localparam int SLOT_ISR       = 2;
  localparam int SLOT_IMR       = 3;
  localparam int SLOT_LIM_FIRST = 4;
  localparam int SLOT_RSVD      = 7;
  localparam int SLOT_LIM_LAST  = 11;
  localparam int SLOT_RXDESC    = 12;
  localparam int SLOT_RXDONE    = 14;
  localparam int SLOT_RXWAIT    = 16;
  localparam int SLOT_TXDESC    = 18;
  localparam int SLOT_TXDONE    = 20;
  localparam int SLOT_TXWAIT    = 22;
  localparam int SLOT_HWADDR    = 24;
  localparam int WORD_W         = 32;

  // descriptor of one 4-byte slot; odd slots above the limits are upper halves
  function automatic slot_t slot_info(int idx);
    slot_t s;
    s = '0;
    if (idx == SLOT_CFG || idx == SLOT_ISR || idx == SLOT_IMR)
      s = '{1'b1, 1'b0, 1'b1, 1'b1};
    else if (idx == SLOT_CMD)
      s = '{1'b1, 1'b0, 1'b0, 1'b1};
    else if (idx >= SLOT_LIM_FIRST && idx <= SLOT_LIM_LAST && idx != SLOT_RSVD)
      s = '{1'b1, 1'b0, 1'b1, 1'b0};
    else if (idx >= SLOT_RXDESC && idx <= SLOT_HWADDR && (idx % 2) == 0)
      s = '{1'b1, 1'b1, 1'b1, (idx == SLOT_RXDESC || idx == SLOT_TXDESC)};
    return s;
  endfunction

endpackage

// File: rtl/nic_reg_check.sv
module nic_reg_check
  import nic_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WINDOW = 'h68,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              bad
);

  slot_t info;
  logic  in_win;
  logic  aligned;
  logic  allowed;

  always_comb begin
    slot_idx = req_addr[ADDR_W-1:2];
    info     = slot_info(int'(slot_idx));
    in_win   = int'(req_addr) < WINDOW;
    aligned  = (req_addr[1:0] == 2'b00);
    allowed  = req_write ? info.wr : info.rd;
    bad      = !(in_win && aligned && info.used && (req_size == info.wide) && allowed);
  end

endmodule

// File: rtl/nic_reg_store.sv
module nic_reg_store
  import nic_reg_pkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int CFG_W = 9,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [63:0]      wdata,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [CFG_W-1:0] cfg_q,
  output logic [IRQ_W-1:0] isr_q,
  output logic [IRQ_W-1:0] imr_q,
  output logic [63:0]      rx_desc_q,
  output logic [63:0]      tx_desc_q,
  output logic             dev_reset_q
);

  logic             cmd_fire;
  logic             isr_wr;
  logic             isr_rd;
  logic [IRQ_W-1:0] isr_next;

  always_comb begin
    cmd_fire = wr_en && int'(idx) == SLOT_CMD && wdata[0];
    isr_wr   = wr_en && int'(idx) == SLOT_ISR;
    isr_rd   = rd_en && int'(idx) == SLOT_ISR;
    if (isr_wr)      isr_next = wdata[IRQ_W-1:0];
    else if (isr_rd) isr_next = '0;
    else             isr_next = isr_q;
    isr_next = isr_next | irq_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      isr_q       <= '0;
      imr_q       <= '0;
      rx_desc_q   <= '0;
      tx_desc_q   <= '0;
      dev_reset_q <= 1'b0;
    end else begin
      dev_reset_q <= cmd_fire;
      if (cmd_fire) begin
        cfg_q     <= '0;
        imr_q     <= '0;
        rx_desc_q <= '0;
        tx_desc_q <= '0;
        isr_q     <= irq_set;
      end else begin
        isr_q <= isr_next;
        if (wr_en && int'(idx) == SLOT_CFG)    cfg_q     <= wdata[CFG_W-1:0];
        if (wr_en && int'(idx) == SLOT_IMR)    imr_q     <= wdata[IRQ_W-1:0];
        if (wr_en && int'(idx) == SLOT_RXDESC) rx_desc_q <= wdata;
        if (wr_en && int'(idx) == SLOT_TXDESC) tx_desc_q <= wdata;
      end
    end
  end

  AST_IRQ_KEPT: assert property (@(posedge clk) disable iff (rst)
    (|irq_set) |=> ((isr_q & $past(irq_set)) == $past(irq_set))); // R8

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dev_reset_q |-> (cfg_q == '0 && imr_q == '0 && rx_desc_q == '0 && tx_desc_q == '0)); // R10

endmodule

// File: rtl/nic_reg_rdmux.sv
module nic_reg_rdmux
  import nic_reg_pkg::*;
#(
  parameter int                IRQ_W   = 8,
  parameter int                CFG_W   = 9,
  parameter int                IDX_W   = 5,
  parameter logic [8*32-1:0]   LIMITS  = '0,
  parameter logic [63:0]       HW_ADDR = '0
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [CFG_W-1:0] cfg,
  input  logic [IRQ_W-1:0] isr,
  input  logic [IRQ_W-1:0] imr,
  input  logic [63:0]      rx_desc,
  input  logic [63:0]      tx_desc,
  input  logic [63:0]      rx_done,
  input  logic [63:0]      rx_wait,
  input  logic [63:0]      tx_done,
  input  logic [63:0]      tx_wait,
  output logic [63:0]      rdata
);

  always_comb begin
    rdata = '0;
    case (int'(idx))
      SLOT_CFG:    rdata = 64'(cfg);
      SLOT_ISR:    rdata = 64'(isr);
      SLOT_IMR:    rdata = 64'(imr);
      SLOT_RXDESC: rdata = rx_desc;
      SLOT_RXDONE: rdata = rx_done;
      SLOT_RXWAIT: rdata = rx_wait;
      SLOT_TXDESC: rdata = tx_desc;
      SLOT_TXDONE: rdata = tx_done;
      SLOT_TXWAIT: rdata = tx_wait;
      SLOT_HWADDR: rdata = HW_ADDR;
      default: begin
        if (int'(idx) >= SLOT_LIM_FIRST && int'(idx) <= SLOT_LIM_LAST)
          rdata = 64'(LIMITS[(int'(idx) - SLOT_LIM_FIRST)*WORD_W +: WORD_W]);
      end
    endcase
  end

endmodule

// File: rtl/nic_reg_decoder.sv
module nic_reg_decoder
  import nic_reg_pkg::*;
#(
  parameter int              ADDR_W  = 7,
  parameter int              IRQ_W   = 8,
  parameter int              CFG_W   = 9,
  parameter int              WINDOW  = 'h68,
  parameter logic [8*32-1:0] LIMITS  = {32'h0001_0000, 32'h0007_0000, 32'h0008_0000,
                                        32'h0008_0000, 32'h0000_0000, 32'h0000_000A,
                                        32'h0000_0800, 32'h0000_0800},
  parameter logic [63:0]     HW_ADDR = 64'h0000_0012_3456_789A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_size,
  input  logic [63:0]       req_wdata,
  input  logic [IRQ_W-1:0]  irq_set,
  input  logic [63:0]       rx_done_i,
  input  logic [63:0]       rx_wait_i,
  input  logic [63:0]       tx_done_i,
  input  logic [63:0]       tx_wait_i,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [IRQ_W-1:0]  imr_o,
  output logic [63:0]       rx_desc_o,
  output logic [63:0]       tx_desc_o,
  output logic              dev_reset_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] slot_idx;
  logic             bad;
  logic             wr_en;
  logic             rd_en;
  logic [IRQ_W-1:0] isr_q;
  logic [63:0]      mux_data;

  nic_reg_check #(.ADDR_W(ADDR_W), .WINDOW(WINDOW)) u_check (
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .slot_idx  (slot_idx),
    .bad       (bad)
  );

  assign wr_en = req_valid && req_write && !bad;
  assign rd_en = req_valid && !req_write && !bad;

  nic_reg_store #(.IRQ_W(IRQ_W), .CFG_W(CFG_W), .IDX_W(IDX_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .idx         (slot_idx),
    .wdata       (req_wdata),
    .irq_set     (irq_set),
    .cfg_q       (cfg_o),
    .isr_q       (isr_q),
    .imr_q       (imr_o),
    .rx_desc_q   (rx_desc_o),
    .tx_desc_q   (tx_desc_o),
    .dev_reset_q (dev_reset_o)
  );

  nic_reg_rdmux #(.IRQ_W(IRQ_W), .CFG_W(CFG_W), .IDX_W(IDX_W),
                  .LIMITS(LIMITS), .HW_ADDR(HW_ADDR)) u_rdmux (
    .idx     (slot_idx),
    .cfg     (cfg_o),
    .isr     (isr_q),
    .imr     (imr_o),
    .rx_desc (rx_desc_o),
    .tx_desc (tx_desc_o),
    .rx_done (rx_done_i),
    .rx_wait (rx_wait_i),
    .tx_done (tx_done_i),
    .tx_wait (tx_wait_i),
    .rdata   (mux_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= rd_en ? mux_data : '0;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_err)); // R2

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R4

  AST_REJECTED_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && bad) |=>
      ($stable(cfg_o) && $stable(imr_o) && $stable(rx_desc_o) && $stable(tx_desc_o) && !dev_reset_o)); // R5

endmodule

// File: tb/sim_nic_reg_decoder.sv
module sim_nic_reg_decoder;

  localparam logic [8*32-1:0] LIMS = {32'h0000_4000, 32'h0003_0000, 32'h0004_0000,
                                      32'h0005_0000, 32'h0000_0000, 32'h0000_0007,
                                      32'h0000_0600, 32'h0000_0500};
  localparam logic [63:0] HWA = 64'h0000_00AB_CDEF_0123;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  irq_set = '0;
  logic [63:0] rx_done_i = '0, rx_wait_i = '0, tx_done_i = '0, tx_wait_i = '0;
  logic        rsp_valid, rsp_err, dev_reset_o;
  logic [63:0] rsp_rdata, rx_desc_o, tx_desc_o;
  logic [8:0]  cfg_o;
  logic [7:0]  imr_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [8:0]  m_cfg = '0;
  logic [7:0]  m_mask = '0, m_isr = '0;
  logic [63:0] m_rx = '0, m_tx = '0;

  always #4 clk = ~clk;

  nic_reg_decoder #(.LIMITS(LIMS), .HW_ADDR(HWA)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_set(irq_set), .rx_done_i(rx_done_i), .rx_wait_i(rx_wait_i),
    .tx_done_i(tx_done_i), .tx_wait_i(tx_wait_i), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cfg_o(cfg_o), .imr_o(imr_o),
    .rx_desc_o(rx_desc_o), .tx_desc_o(tx_desc_o), .dev_reset_o(dev_reset_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // slot map written per byte offset (R3, R5)
  task automatic exp_slot(input logic [6:0] a, output bit used, output bit wide,
                          output bit rd, output bit wr);
    used = 0; wide = 0; rd = 0; wr = 0;
    case (a)
      7'h00, 7'h08, 7'h0C: begin used = 1; rd = 1; wr = 1; end
      7'h04: begin used = 1; wr = 1; end
      7'h10, 7'h14, 7'h18, 7'h20, 7'h24, 7'h28, 7'h2C: begin used = 1; rd = 1; end
      7'h30, 7'h48: begin used = 1; wide = 1; rd = 1; wr = 1; end
      7'h38, 7'h40, 7'h50, 7'h58, 7'h60: begin used = 1; wide = 1; rd = 1; end
      default: ;
    endcase
  endtask

  function automatic logic [63:0] exp_read(input logic [6:0] a);
    case (a)
      7'h00: return 64'(m_cfg);
      7'h08: return 64'(m_isr);
      7'h0C: return 64'(m_mask);
      7'h10: return 64'(LIMS[31:0]);
      7'h14: return 64'(LIMS[63:32]);
      7'h18: return 64'(LIMS[95:64]);
      7'h20: return 64'(LIMS[159:128]);
      7'h24: return 64'(LIMS[191:160]);
      7'h28: return 64'(LIMS[223:192]);
      7'h2C: return 64'(LIMS[255:224]);
      7'h30: return m_rx;
      7'h38: return rx_done_i;
      7'h40: return rx_wait_i;
      7'h48: return m_tx;
      7'h50: return tx_done_i;
      7'h58: return tx_wait_i;
      7'h60: return HWA;
      default: return '0;
    endcase
  endfunction

  // one request cycle: drive at falling edge, check at the next falling edge
  task automatic xact(input bit v, input bit w, input logic [6:0] a, input bit sz,
                      input logic [63:0] d, input logic [7:0] irq);
    bit used, wide, rd, wr, ok, cmd;
    logic [63:0] er;
    string etag, rtag;
    req_valid = v; req_write = w; req_addr = a; req_size = sz; req_wdata = d; irq_set = irq;
    exp_slot(a, used, wide, rd, wr);
    ok   = v && used && (sz == wide) && (w ? wr : rd);
    etag = !used ? "R3" : (sz != wide) ? "R4" : "R5";
    rtag = (a == 7'h08) ? "R8" : "R6";
    er   = (ok && !w) ? exp_read(a) : 64'h0;
    cmd  = ok && w && a == 7'h04 && d[0];
    if (cmd) begin
      m_cfg = '0; m_mask = '0; m_rx = '0; m_tx = '0; m_isr = irq;
    end else begin
      if (ok && w && a == 7'h00) m_cfg = d[8:0];
      if (ok && w && a == 7'h0C) m_mask = d[7:0];
      if (ok && w && a == 7'h30) m_rx = d;
      if (ok && w && a == 7'h48) m_tx = d;
      m_isr = ((ok && w && a == 7'h08) ? d[7:0] :
               (ok && !w && a == 7'h08) ? 8'h00 : m_isr) | irq;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", 64'(rsp_valid), 64'(v));
    chk(etag, 64'(rsp_err), 64'(v && !ok));
    chk(rtag, rsp_rdata, er);
    chk("R7", 64'(cfg_o), 64'(m_cfg));
    chk("R7", 64'(imr_o), 64'(m_mask));
    chk("R11", rx_desc_o, m_rx);
    chk("R11", tx_desc_o, m_tx);
    chk("R10", 64'(dev_reset_o), 64'(cmd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd61453));
    rx_done_i = {$urandom, $urandom};
    rx_wait_i = {$urandom, $urandom};
    tx_done_i = {$urandom, $urandom};
    tx_wait_i = {$urandom, $urandom};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", 64'(rsp_valid), 0);
    chk("R1", 64'(rsp_err), 0);
    chk("R1", rsp_rdata, 0);
    chk("R1", 64'(cfg_o), 0);
    chk("R1", 64'(imr_o), 0);
    chk("R1", rx_desc_o | tx_desc_o, 0);
    chk("R1", 64'(dev_reset_o), 0);
    xact(1, 0, 7'h08, 0, 0, 8'h00);
    chk("R1", rsp_rdata, 0);

    // R7: config and mask writes drop upper bits
    xact(1, 1, 7'h00, 0, 64'hFFFF_FFFF_FFFF_FE5A, 0);
    xact(1, 1, 7'h0C, 0, 64'h0000_0000_0000_1F3C, 0);
    // R11: descriptor writes
    xact(1, 1, 7'h30, 1, 64'h1234_5678_9ABC_DEF0, 0);
    xact(1, 1, 7'h48, 1, 64'hFEDC_BA98_7654_3210, 0);
    // R3: outside window, reserved slot, upper half, misaligned
    xact(1, 0, 7'h68, 0, 0, 0);
    xact(1, 0, 7'h7C, 0, 0, 0);
    xact(1, 0, 7'h1C, 0, 0, 0);
    xact(1, 0, 7'h34, 0, 0, 0);
    xact(1, 1, 7'h02, 0, 64'h1FF, 0);
    // R4: width mismatch
    xact(1, 0, 7'h00, 1, 0, 0);
    xact(1, 1, 7'h30, 0, 64'h5555, 0);
    // R5: rights
    xact(1, 1, 7'h10, 0, 64'hAAAA, 0);
    xact(1, 0, 7'h04, 0, 0, 0);
    xact(1, 1, 7'h60, 1, 64'h1, 0);
    // R6: read-only values
    xact(1, 0, 7'h18, 0, 0, 0);
    xact(1, 0, 7'h60, 1, 0, 0);
    xact(1, 0, 7'h40, 1, 0, 0);
    // R9: events set status, write loads it
    xact(1, 0, 7'h00, 0, 0, 8'h21);
    xact(1, 1, 7'h08, 0, 64'h0000_0000_0000_FF84, 8'h01);
    xact(1, 0, 7'h08, 0, 0, 0);
    chk("R9", rsp_rdata, 64'h85);
    // R8: read clears, same-cycle event survives
    xact(1, 0, 7'h08, 0, 0, 8'h40);
    xact(0, 0, 7'h00, 0, 0, 0);
    xact(1, 0, 7'h08, 0, 0, 0);
    chk("R8", rsp_rdata, 64'h40);
    // R10: bit0 clear has no effect, bit0 set resets
    xact(1, 1, 7'h04, 0, 64'hFFFF_FFFE, 0);
    xact(1, 1, 7'h04, 0, 64'h1, 8'h02);
    xact(1, 0, 7'h08, 0, 0, 0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v, w, sz;
      logic [6:0] a;
      logic [63:0] d;
      logic [7:0] irq;
      v   = ($urandom_range(0, 7) != 0);
      w   = $urandom_range(0, 1) == 1;
      a   = 7'(4 * $urandom_range(0, 31));
      if ($urandom_range(0, 9) == 0) a = a | 7'($urandom_range(1, 3));
      sz  = ($urandom_range(0, 5) == 0) ? 1'b0 : (a >= 7'h30);
      if ($urandom_range(0, 7) == 0) sz = ~sz;
      d   = {$urandom, $urandom};
      if (a == 7'h04) d[0] = ($urandom_range(0, 7) == 0);
      irq = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      xact(v, w, a, sz, d, irq);
    end
    req_valid = 1'b0;
    irq_set   = '0;
    report();
  end

endmodule